// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a simple single-bus processor. It keeps a micro-address counter and a small control store of microinstructions. Each cycle it loads the microinstruction at the chosen address into a registered microinstruction word. The gating, memory and ALU strobes are driven from that word. The datapath, the main memory and the ALU sit outside the block. The sequencer only sees the upper byte of the instruction register, the negative flag and a memory-done handshake.

Every instruction starts with a shared three-step fetch. A dispatch step then jumps to the instruction's microroutine. For the add opcode the dispatch does not use a table entry for each mode. It takes a fixed base address and overwrites selected counter bits from the mode field. A later step inside the operand routine picks the indirect or the direct path from one instruction bit. A wait flag in a microinstruction stalls the whole unit until memory reports completion. A conditional step restarts the fetch when the result is not negative. An end flag also returns the unit to the fetch.

Top module: `ucode_sequencer`

## Requirements
- R1: Reset is synchronous and active high. While it is held, `uaddr_o` is 0 and every control output is 0. In the first cycle after release, the word at address 0 is presented.
- R2: A microinstruction with no stall, no end flag and no branch is followed by the one at the next address up.
- R3: The fetch words are fixed. Address 0 sets gate bits 0, 2 and 6 plus `mem_rd_o`, `alu_four_o` and `alu_add_o`. Address 1 sets gate bits 1, 5 and 7 plus `mem_wait_o`. Address 2 sets gate bits 3 and 4.
- R4: Octal address 003 dispatches. When the opcode `ir_hi_i[7:3]` is 00001 (add), the next address is octal 101 with bits 5:4 replaced by `ir_hi_i[2:1]` (instruction bits 10:9). Bit 3 is set exactly when instruction bits 10:8 equal 001.
- R5: At the dispatch, opcode 00010 (branch if negative) goes to octal 025. Every other opcode goes to octal 060, which is an unused location.
- R6: An unused control-store location drives every gate, memory and ALU output low and raises `fin_o`.
- R7: Octal 122 branches to octal 170 with address bit 0 taken from `ir_hi_i[0]` (instruction bit 8). A value of 1 skips the extra indirect read at 170 and goes to 171.
- R8: While `mem_wait_o` is high and `mfc_i` is low, the address and all outputs hold. The unit moves on at the first edge at which `mfc_i` is sampled high. When no wait is requested, `mfc_i` has no effect.
- R9: At octal 025, `neg_i` low sends the unit to address 0 and `neg_i` high sends it to octal 026.
- R10: A word with `fin_o` high is followed by address 0, unless it is stalled. The end words sit at octal 027, 103, 114 and 173 and at every unused location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_hi_i | input | 8 | Instruction register bits 15:8 (opcode in 7:3, mode in 2:0) |
| neg_i | input | 1 | Negative condition flag |
| mfc_i | input | 1 | Memory function completed |
| gate_o | output | 13 | Bus gating strobes: 0 PC out, 1 PC in, 2 MAR in, 3 MDR out, 4 IR in, 5 Y in, 6 Z in, 7 Z out, 8 source out, 9 source in, 10 destination out, 11 destination in, 12 offset out |
| mem_rd_o | output | 1 | Memory read request |
| mem_wait_o | output | 1 | Wait for memory completion |
| alu_four_o | output | 1 | ALU A operand is the constant 4 (else Y) |
| alu_add_o | output | 1 | ALU adds |
| fin_o | output | 1 | End of microroutine |
| uaddr_o | output | 8 | Address of the microinstruction now in the register |

## Verification
The assertions assume that `ir_hi_i`, `neg_i` and `mfc_i` are valid at each edge once reset is released. They also assume that the instruction byte does not change between the dispatch and the operand branch that reads it again. The stimulus changes the instruction byte only while the third fetch word is active, which is when the modelled instruction register loads. It holds `mfc_i` low for a random latency of up to six cycles while a wait is requested and toggles it freely at other times. `neg_i` is re-drawn every cycle, or forced during directed branch cases. Opcodes are drawn from add, branch and arbitrary bytes, so that every mode and some illegal values are reached.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int GATE_W = 13;

  // Gate strobe bit positions (visible at the gate output port)
  localparam int G_PC_DRV  = 0;
  localparam int G_PC_LD   = 1;
  localparam int G_MAR_LD  = 2;
  localparam int G_MDR_DRV = 3;
  localparam int G_IR_LD   = 4;
  localparam int G_Y_LD    = 5;
  localparam int G_Z_LD    = 6;
  localparam int G_Z_DRV   = 7;
  localparam int G_SRC_DRV = 8;
  localparam int G_SRC_LD  = 9;
  localparam int G_DST_DRV = 10;
  localparam int G_DST_LD  = 11;
  localparam int G_OFS_DRV = 12;

  localparam logic [GATE_W-1:0] M_PC_DRV  = GATE_W'(1) << G_PC_DRV;
  localparam logic [GATE_W-1:0] M_PC_LD   = GATE_W'(1) << G_PC_LD;
  localparam logic [GATE_W-1:0] M_MAR_LD  = GATE_W'(1) << G_MAR_LD;
  localparam logic [GATE_W-1:0] M_MDR_DRV = GATE_W'(1) << G_MDR_DRV;
  localparam logic [GATE_W-1:0] M_IR_LD   = GATE_W'(1) << G_IR_LD;
  localparam logic [GATE_W-1:0] M_Y_LD    = GATE_W'(1) << G_Y_LD;
  localparam logic [GATE_W-1:0] M_Z_LD    = GATE_W'(1) << G_Z_LD;
  localparam logic [GATE_W-1:0] M_Z_DRV   = GATE_W'(1) << G_Z_DRV;
  localparam logic [GATE_W-1:0] M_SRC_DRV = GATE_W'(1) << G_SRC_DRV;
  localparam logic [GATE_W-1:0] M_SRC_LD  = GATE_W'(1) << G_SRC_LD;
  localparam logic [GATE_W-1:0] M_DST_DRV = GATE_W'(1) << G_DST_DRV;
  localparam logic [GATE_W-1:0] M_DST_LD  = GATE_W'(1) << G_DST_LD;
  localparam logic [GATE_W-1:0] M_OFS_DRV = GATE_W'(1) << G_OFS_DRV;

  // Opcodes (instruction bits 15:11)
  localparam int OPC_ADD = 1;
  localparam int OPC_NEG = 2;

  // Control-store addresses whose values the sequencing depends on
  localparam int UA_DISP    = 'o003;
  localparam int UA_NEG     = 'o025;
  localparam int UA_BAD     = 'o060;
  localparam int UA_ADD     = 'o101;
  localparam int UA_OPND    = 'o170;

  typedef enum logic [1:0] {
    SQ_STEP = 2'd0,
    SQ_DISP = 2'd1,
    SQ_OPND = 2'd2,
    SQ_NEG  = 2'd3
  } seq_e;

  typedef struct packed {
    logic [GATE_W-1:0] gate;
    logic              mrd;
    logic              mwait;
    logic              sel4;
    logic              add;
    logic              fin;
    seq_e              seq;
  } uword_t;

  function automatic uword_t uw(logic [GATE_W-1:0] g, logic r, logic w,
                                logic s4, logic ad, logic f, seq_e sq);
    uword_t x;
    x.gate  = g;
    x.mrd   = r;
    x.mwait = w;
    x.sel4  = s4;
    x.add   = ad;
    x.fin   = f;
    x.seq   = sq;
    return x;
  endfunction

endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int UADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [UADDR_W-1:0] addr_i,
  output uword_t             word_o
);

  function automatic uword_t lookup(logic [UADDR_W-1:0] a);
    uword_t w;
    case (a)
      UADDR_W'('o000): w = uw(M_PC_DRV | M_MAR_LD | M_Z_LD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, SQ_STEP);
      UADDR_W'('o001): w = uw(M_Z_DRV | M_PC_LD | M_Y_LD,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o002): w = uw(M_MDR_DRV | M_IR_LD,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o003): w = uw('0,                           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SQ_DISP);
      // branch if negative
      UADDR_W'('o025): w = uw('0,                           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SQ_NEG);
      UADDR_W'('o026): w = uw(M_OFS_DRV | M_Z_LD,           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, SQ_STEP);
      UADDR_W'('o027): w = uw(M_Z_DRV | M_PC_LD,            1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SQ_STEP);
      // add, register source
      UADDR_W'('o101): w = uw(M_SRC_DRV | M_Y_LD,           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o102): w = uw(M_DST_DRV | M_Z_LD,           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, SQ_STEP);
      UADDR_W'('o103): w = uw(M_Z_DRV | M_DST_LD,           1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SQ_STEP);
      // add, register-indirect source
      UADDR_W'('o111): w = uw(M_SRC_DRV | M_MAR_LD,         1'b1, 1'b1, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o112): w = uw(M_MDR_DRV | M_Y_LD,           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o113): w = uw(M_DST_DRV | M_Z_LD,           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, SQ_STEP);
      UADDR_W'('o114): w = uw(M_Z_DRV | M_DST_LD,           1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SQ_STEP);
      // add, auto-increment source (direct or indirect)
      UADDR_W'('o121): w = uw(M_SRC_DRV | M_MAR_LD | M_Z_LD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, SQ_STEP);
      UADDR_W'('o122): w = uw(M_Z_DRV | M_SRC_LD,           1'b0, 1'b1, 1'b0, 1'b0, 1'b0, SQ_OPND);
      UADDR_W'('o170): w = uw(M_MDR_DRV | M_MAR_LD,         1'b1, 1'b1, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o171): w = uw(M_MDR_DRV | M_Y_LD,           1'b0, 1'b0, 1'b0, 1'b0, 1'b0, SQ_STEP);
      UADDR_W'('o172): w = uw(M_DST_DRV | M_Z_LD,           1'b0, 1'b0, 1'b0, 1'b1, 1'b0, SQ_STEP);
      UADDR_W'('o173): w = uw(M_Z_DRV | M_DST_LD,           1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SQ_STEP);
      default:         w = uw('0,                           1'b0, 1'b0, 1'b0, 1'b0, 1'b1, SQ_STEP);
    endcase
    return w;
  endfunction

  // Synchronous read: the microinstruction register is the ROM output register
  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= lookup(addr_i);
  end

endmodule

// File: rtl/ucode_next.sv
module ucode_next
  import ucode_pkg::*;
#(
  parameter int UADDR_W = 8,
  parameter int OPC_W   = 5
) (
  input  logic [UADDR_W-1:0] upc_i,
  input  uword_t             word_i,
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [2:0]         mode_i,
  input  logic               neg_i,
  input  logic               mfc_i,
  input  logic               started_i,
  output logic [UADDR_W-1:0] next_o
);

  logic [UADDR_W-1:0] incr;
  logic [UADDR_W-1:0] disp;

  assign incr = upc_i + UADDR_W'(1);

  // Dispatch: base address, then selected bits forced from the mode field
  always_comb begin
    if (opc_i == OPC_W'(OPC_ADD)) begin
      disp    = UADDR_W'(UA_ADD);
      disp[5] = mode_i[2];
      disp[4] = mode_i[1];
      disp[3] = ~mode_i[2] & ~mode_i[1] & mode_i[0];
    end else if (opc_i == OPC_W'(OPC_NEG)) begin
      disp = UADDR_W'(UA_NEG);
    end else begin
      disp = UADDR_W'(UA_BAD);
    end
  end

  always_comb begin
    next_o = incr;
    if (!started_i) begin
      next_o = '0;
    end else if (word_i.mwait && !mfc_i) begin
      next_o = upc_i;
    end else if (word_i.fin) begin
      next_o = '0;
    end else begin
      case (word_i.seq)
        SQ_DISP: next_o = disp;
        SQ_OPND: begin
          next_o    = UADDR_W'(UA_OPND);
          next_o[0] = mode_i[0];
        end
        SQ_NEG:  next_o = neg_i ? incr : '0;
        default: next_o = incr;
      endcase
    end
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
#(
  parameter int IR_W    = 16,
  parameter int UADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IR_W-9:0]      ir_hi_i,
  input  logic                 neg_i,
  input  logic                 mfc_i,
  output logic [GATE_W-1:0]    gate_o,
  output logic                 mem_rd_o,
  output logic                 mem_wait_o,
  output logic                 alu_four_o,
  output logic                 alu_add_o,
  output logic                 fin_o,
  output logic [UADDR_W-1:0]   uaddr_o
);

  localparam int OPC_W = IR_W - 11;

  logic [UADDR_W-1:0] upc_q;
  logic [UADDR_W-1:0] upc_d;
  logic               started_q;
  uword_t             word;

  ucode_next #(.UADDR_W(UADDR_W), .OPC_W(OPC_W)) u_next (
    .upc_i     (upc_q),
    .word_i    (word),
    .opc_i     (ir_hi_i[IR_W-9:3]),
    .mode_i    (ir_hi_i[2:0]),
    .neg_i     (neg_i),
    .mfc_i     (mfc_i),
    .started_i (started_q),
    .next_o    (upc_d)
  );

  ucode_store #(.UADDR_W(UADDR_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .addr_i (upc_d),
    .word_o (word)
  );

  // Counter tracks the address of the word in the microinstruction register
  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q     <= '0;
      started_q <= 1'b0;
    end else begin
      upc_q     <= upc_d;
      started_q <= 1'b1;
    end
  end

  assign gate_o     = word.gate;
  assign mem_rd_o   = word.mrd;
  assign mem_wait_o = word.mwait;
  assign alu_four_o = word.sel4;
  assign alu_add_o  = word.add;
  assign fin_o      = word.fin;
  assign uaddr_o    = upc_q;

  logic stall;
  assign stall = word.mwait && !mfc_i;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (upc_q == '0 && word == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (started_q && !stall && !word.fin && word.seq == SQ_STEP)
    |=> (upc_q == $past(upc_q) + UADDR_W'(1)));

  p_dispatch_add_r4: assert property (@(posedge clk) disable iff (rst)
    (started_q && !stall && !word.fin && word.seq == SQ_DISP &&
     ir_hi_i[IR_W-9:3] == OPC_W'(OPC_ADD))
    |=> (upc_q[5:4] == $past(ir_hi_i[2:1]) &&
         upc_q[3] == ($past(ir_hi_i[2:0]) == 3'b001)));

  p_opnd_branch_r7: assert property (@(posedge clk) disable iff (rst)
    (started_q && !stall && !word.fin && word.seq == SQ_OPND)
    |=> (upc_q[UADDR_W-1:1] == (UADDR_W-1)'(UA_OPND >> 1) &&
         upc_q[0] == $past(ir_hi_i[0])));

  p_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (started_q && stall) |=> ($stable(upc_q) && $stable(word)));

  p_neg_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (started_q && !stall && !word.fin && word.seq == SQ_NEG && !neg_i)
    |=> (upc_q == '0));

  p_end_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (started_q && !stall && word.fin) |=> (upc_q == '0));

endmodule

// File: tb/ucode_sequencer_bench.sv
`timescale 1ns/1ps
module ucode_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ir_hi = '0;
  logic        neg = 1'b0;
  logic        mfc = 1'b0;
  logic [12:0] gate_o;
  logic        mem_rd_o, mem_wait_o, alu_four_o, alu_add_o, fin_o;
  logic [7:0]  uaddr_o;

  always #2 clk = ~clk;

  ucode_sequencer u_ucode_sequencer (
    .clk(clk), .rst(rst), .ir_hi_i(ir_hi), .neg_i(neg), .mfc_i(mfc),
    .gate_o(gate_o), .mem_rd_o(mem_rd_o), .mem_wait_o(mem_wait_o),
    .alu_four_o(alu_four_o), .alu_add_o(alu_add_o), .fin_o(fin_o),
    .uaddr_o(uaddr_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
    end
  endtask

  function automatic bit known(logic [7:0] a);
    case (a)
      8'o000, 8'o001, 8'o002, 8'o003, 8'o025, 8'o026, 8'o027,
      8'o101, 8'o102, 8'o103, 8'o111, 8'o112, 8'o113, 8'o114,
      8'o121, 8'o122, 8'o170, 8'o171, 8'o172, 8'o173: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_wait(logic [7:0] a);
    return a == 8'o001 || a == 8'o111 || a == 8'o122 || a == 8'o170;
  endfunction

  function automatic bit is_fin(logic [7:0] a);
    return !known(a) || a == 8'o027 || a == 8'o103 || a == 8'o114 || a == 8'o173;
  endfunction

  // Routine entry by mode, written as a table rather than bit forcing
  function automatic logic [7:0] disp_target(logic [7:0] hi);
    if (hi[7:3] == 5'd1) begin
      case (hi[2:0])
        3'd0:       return 8'o101;
        3'd1:       return 8'o111;
        3'd2, 3'd3: return 8'o121;
        3'd4, 3'd5: return 8'o141;
        default:    return 8'o161;
      endcase
    end else if (hi[7:3] == 5'd2) return 8'o025;
    return 8'o060;
  endfunction

  // {gate, rd, wait, four, add} of the fetch words
  function automatic logic [16:0] fetch_word(logic [7:0] a);
    case (a)
      8'o000:  return {13'h045, 4'b1011};
      8'o001:  return {13'h0A2, 4'b0100};
      default: return {13'h018, 4'b0000};
    endcase
  endfunction

  logic [7:0] dir_ir [12];
  bit         dir_n  [12];

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WDOG", "timeout", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  exp_a;
    logic [7:0]  nxt;
    logic [16:0] prev_out;
    string       tag;
    bit          held;
    bit          dir_mode;
    bit          fn;
    bit          first_wait;
    int          idx;
    int          wcnt;
    int          lat;

    void'($urandom(32'd20240611));
    dir_ir[0]  = 8'b00001_000; dir_n[0]  = 0;
    dir_ir[1]  = 8'b00001_001; dir_n[1]  = 0;
    dir_ir[2]  = 8'b00001_010; dir_n[2]  = 0;
    dir_ir[3]  = 8'b00001_011; dir_n[3]  = 0;
    dir_ir[4]  = 8'b00010_000; dir_n[4]  = 0;
    dir_ir[5]  = 8'b00010_000; dir_n[5]  = 1;
    dir_ir[6]  = 8'b00001_100; dir_n[6]  = 0;
    dir_ir[7]  = 8'b00001_110; dir_n[7]  = 0;
    dir_ir[8]  = 8'b00000_000; dir_n[8]  = 0;
    dir_ir[9]  = 8'b11111_111; dir_n[9]  = 0;
    dir_ir[10] = 8'b00001_101; dir_n[10] = 0;
    dir_ir[11] = 8'b00001_111; dir_n[11] = 0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(uaddr_o == 8'd0, "R1", "uaddr in reset", uaddr_o, 0);
    chk({gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o, fin_o} == '0,
        "R1", "outputs in reset",
        {gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o, fin_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    exp_a = 8'o000; tag = "R1"; held = 0; prev_out = '0;
    idx = 0; wcnt = 0; lat = 0; dir_mode = 0; fn = 0; first_wait = 1;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      chk(uaddr_o == exp_a, tag, "micro-address", uaddr_o, exp_a);
      if (exp_a <= 8'o002)
        chk({gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o} == fetch_word(exp_a),
            "R3", "fetch word", {gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o},
            fetch_word(exp_a));
      if (!known(exp_a))
        chk({gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o, fin_o} == 18'd1,
            "R6", "unused word", {gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o, fin_o}, 1);
      chk(fin_o == is_fin(exp_a), "R10", "end flag", fin_o, is_fin(exp_a));
      chk(mem_wait_o == is_wait(exp_a), "R8", "wait flag", mem_wait_o, is_wait(exp_a));
      if (held)
        chk({gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o} == prev_out,
            "R8", "outputs held in stall",
            {gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o}, prev_out);
      prev_out = {gate_o, mem_rd_o, mem_wait_o, alu_four_o, alu_add_o};

      // Modelled instruction register loads during the third fetch word
      if (exp_a == 8'o002) begin
        if (idx < 12) begin
          ir_hi = dir_ir[idx]; fn = dir_n[idx]; dir_mode = 1;
        end else begin
          dir_mode = 0;
          case ($urandom % 4)
            0, 1:    ir_hi = {5'd1, 3'($urandom)};
            2:       ir_hi = {5'd2, 3'($urandom)};
            default: ir_hi = 8'($urandom);
          endcase
        end
        idx++;
      end

      neg = (exp_a == 8'o025 && dir_mode) ? fn : 1'($urandom);

      if (is_wait(exp_a)) begin
        if (wcnt == 0) begin
          lat = first_wait ? 6 : int'($urandom % 5);
          first_wait = 0;
        end
        mfc = (wcnt >= lat);
        wcnt = mfc ? 0 : wcnt + 1;
      end else begin
        mfc = 1'($urandom);
        wcnt = 0;
      end

      // Reference next address
      held = 0;
      if (is_wait(exp_a) && !mfc) begin
        nxt = exp_a; tag = "R8"; held = 1;
      end else if (is_fin(exp_a)) begin
        nxt = 8'o000; tag = known(exp_a) ? "R10" : "R6";
      end else if (exp_a == 8'o003) begin
        nxt = disp_target(ir_hi);
        tag = (ir_hi[7:3] == 5'd1) ? "R4" : "R5";
      end else if (exp_a == 8'o122) begin
        nxt = ir_hi[0] ? 8'o171 : 8'o170; tag = "R7";
      end else if (exp_a == 8'o025) begin
        nxt = neg ? 8'o026 : 8'o000; tag = "R9";
      end else begin
        nxt = exp_a + 8'd1; tag = "R2";
      end
      exp_a = nxt;
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule